// File: doc/BRIEF.md
# Shadow Data Translation Buffer with Second-Level Refill

This block is a small first-level translation buffer for the load/store path. It holds a handful of page translations. Each slot has a valid flag, a virtual page tag and a physical page number, and any page may sit in any slot. When data relocation is switched on, each data access compares its virtual page number against every slot at once. On a hit, the physical address comes back in the same cycle. On a miss, the access is held busy while the block asks a shared second-level translation buffer for the page. The answer is installed in the slot picked by a round-robin pointer, and the held access then completes through a normal hit.

The second-level buffer is shared with the instruction side, and the data side has priority whenever both sides want it. A refill takes a fixed minimum of three extra cycles. If the second-level buffer is slower to answer, the refill takes longer. Replacement and invalidation are handled entirely in hardware. An invalidate-all input empties the buffer in one cycle. When relocation is off, addresses pass straight through and the buffer is left untouched.

Top module: `dtlb_shadow`

## Requirements
- R1: After reset every slot is invalid, the round-robin pointer is 0, `l2_req` and `acc_busy` are low, and the first translated access to any page misses.
- R2: With `reloc_en` = 0, a valid access gets `acc_done` = 1 in the same cycle with `acc_paddr` equal to `acc_vaddr`, and no refill request is raised.
- R3: A translated access whose page number (address bits [31:12]) matches a valid slot gets `acc_done` in the same cycle. Its `acc_paddr` is the stored physical page number in bits [31:12], with the offset bits [11:0] copied from the virtual address. At most one slot matches.
- R4: A translated miss raises `l2_req` in the next cycle, with `l2_vpn` equal to the missing page number. Both stay unchanged until a cycle in which `l2_resp_valid` is 1.
- R5: Suppose a miss is first presented in cycle T and the second-level buffer answers in the first cycle of the request. Then `acc_done` rises in cycle T+3. Each cycle the answer is delayed adds one cycle.
- R6: While a translated access waits on a refill, `acc_busy` is 1 and `acc_done` is 0. `acc_busy` and `acc_done` are never both 1.
- R7: New entries fill slots in round-robin order and wrap from the last slot to slot 0. With all slots full, a refill evicts the entry that was installed earliest.
- R8: The round-robin pointer moves only when an entry is installed. Hits and passthrough accesses leave the eviction order unchanged.
- R9: `inv_all` clears every valid flag and resets the pointer to 0 at the next clock edge. An install that falls on the same edge is dropped, and the held access then misses again and issues a new request.
- R10: `ins_grant` equals `ins_req` while `l2_req` is low, and is 0 while `l2_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reloc_en | input | 1 | Data relocation enable |
| acc_valid | input | 1 | Data access present; held with its address while busy |
| acc_vaddr | input | ADDR_W | Effective address of the access |
| acc_done | output | 1 | Access translated this cycle |
| acc_busy | output | 1 | Access stalled on a refill |
| acc_paddr | output | ADDR_W | Translated (or passed-through) address |
| inv_all | input | 1 | Invalidate every slot |
| l2_req | output | 1 | Refill request to the second-level buffer |
| l2_vpn | output | ADDR_W-OFF_W | Page number being refilled |
| l2_resp_valid | input | 1 | Second-level answer present |
| l2_resp_ppn | input | ADDR_W-OFF_W | Physical page number answered |
| ins_req | input | 1 | Instruction-side request for the second-level buffer |
| ins_grant | output | 1 | Instruction side may use the second-level buffer |

## Verification
The bench builds the block with its defaults: eight slots, 32-bit addresses and a 12-bit page offset. With eight slots, a sweep of nine distinct pages fills the buffer, forces a wrap and shows the first-installed page being evicted. The 20-bit page numbers let the stimulus table hold readable page and frame values. The bench acts as the second-level responder, with an answer latency that varies from 0 to 5 cycles. It also raises the instruction-side request throughout, so that the priority rule is exercised on every refill.

// File: rtl/dtlb_shadow.sv
module dtlb_shadow #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reloc_en,
  input  logic                    acc_valid,
  input  logic [ADDR_W-1:0]       acc_vaddr,
  output logic                    acc_done,
  output logic                    acc_busy,
  output logic [ADDR_W-1:0]       acc_paddr,
  input  logic                    inv_all,
  output logic                    l2_req,
  output logic [ADDR_W-OFF_W-1:0] l2_vpn,
  input  logic                    l2_resp_valid,
  input  logic [ADDR_W-OFF_W-1:0] l2_resp_ppn,
  input  logic                    ins_req,
  output logic                    ins_grant
);
  localparam int PN_W  = ADDR_W - OFF_W;
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_FILL} st_t;
  st_t st;

  logic [ENTRIES-1:0] vld;
  logic [PN_W-1:0]    tag_q [ENTRIES];
  logic [PN_W-1:0]    ppn_q [ENTRIES];
  logic [PTR_W-1:0]   rr_ptr;
  logic [PN_W-1:0]    pend_vpn, fill_ppn;
  logic [ENTRIES-1:0] hit_vec;
  logic [PN_W-1:0]    hit_ppn;

  wire [PN_W-1:0] vpn    = acc_vaddr[ADDR_W-1:OFF_W];
  wire            lookup = acc_valid & reloc_en & (st == S_IDLE);
  wire            any_hit = |hit_vec;
  wire            miss   = lookup & ~any_hit;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i] = vld[i] & (tag_q[i] == vpn);
  end

  always_comb begin
    hit_ppn = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) hit_ppn = hit_ppn | ppn_q[i];
  end

  assign acc_done  = acc_valid & (~reloc_en | (lookup & any_hit));
  assign acc_busy  = acc_valid & reloc_en & ~acc_done;
  assign acc_paddr = reloc_en ? {hit_ppn, acc_vaddr[OFF_W-1:0]} : acc_vaddr;
  assign l2_req    = (st == S_WAIT);
  assign l2_vpn    = pend_vpn;
  assign ins_grant = ins_req & ~l2_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      vld      <= '0;
      rr_ptr   <= '0;
      pend_vpn <= '0;
      fill_ppn <= '0;
    end else begin
      case (st)
        S_IDLE: if (miss) begin
          pend_vpn <= vpn;
          st       <= S_WAIT;
        end
        S_WAIT: if (l2_resp_valid) begin
          fill_ppn <= l2_resp_ppn;
          st       <= S_FILL;
        end
        default: st <= S_IDLE;
      endcase
      if (inv_all) begin
        vld    <= '0;
        rr_ptr <= '0;
      end else if (st == S_FILL) begin
        vld[rr_ptr] <= 1'b1;
        rr_ptr      <= (rr_ptr == PTR_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_FILL && !inv_all) begin
      tag_q[rr_ptr] <= pend_vpn;
      ppn_q[rr_ptr] <= fill_ppn;
    end
  end

  a_r6_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_busy && acc_done));
  a_r3_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    l2_req && !l2_resp_valid |=> l2_req && $stable(l2_vpn));
  a_r4_req_origin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(l2_req) |-> $past(acc_busy));
  a_r9_inv_clear: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (vld == '0) && (rr_ptr == '0));
  a_r2_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !reloc_en |-> acc_done && (acc_paddr == acc_vaddr));
  a_r8_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_FILL) && !inv_all |=> $stable(rr_ptr));
endmodule

// File: tb/dtlb_shadow_tb.sv
module dtlb_shadow_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reloc_en = 1'b0, acc_valid = 1'b0, inv_all = 1'b0;
  logic l2_resp_valid = 1'b0, ins_req = 1'b1;
  logic [31:0] acc_vaddr = '0;
  logic [19:0] l2_resp_ppn = '0;
  logic acc_done, acc_busy, l2_req, ins_grant;
  logic [31:0] acc_paddr;
  logic [19:0] l2_vpn;

  int checks = 0, errors = 0;
  bit bad_busy = 0, bad_vpn = 0, bad_pri = 0;

  always #4 clk = ~clk;

  dtlb_shadow u_dut (
    .clk(clk), .rst_n(rst_n), .reloc_en(reloc_en), .acc_valid(acc_valid),
    .acc_vaddr(acc_vaddr), .acc_done(acc_done), .acc_busy(acc_busy),
    .acc_paddr(acc_paddr), .inv_all(inv_all), .l2_req(l2_req), .l2_vpn(l2_vpn),
    .l2_resp_valid(l2_resp_valid), .l2_resp_ppn(l2_resp_ppn),
    .ins_req(ins_req), .ins_grant(ins_grant)
  );

  typedef struct packed {
    logic        rel;
    logic [31:0] va;
    int          lat;
    logic [19:0] ppn;
    int          cyc;
    logic [31:0] pa;
    int          nreq;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b1, 32'h0000_1123, 0, 20'hA0001, 3, 32'hA000_1123, 1},
    '{1'b1, 32'h0000_1FFF, 0, 20'h00000, 0, 32'hA000_1FFF, 0},
    '{1'b1, 32'h0000_2004, 2, 20'hA0002, 5, 32'hA000_2004, 1},
    '{1'b0, 32'h1234_5678, 0, 20'h00000, 0, 32'h1234_5678, 0},
    '{1'b1, 32'h0000_2000, 0, 20'h00000, 0, 32'hA000_2000, 0},
    '{1'b1, 32'h0000_3010, 5, 20'hB0003, 8, 32'hB000_3010, 1},
    '{1'b1, 32'h0000_1000, 0, 20'h00000, 0, 32'hA000_1000, 0},
    '{1'b0, 32'h0000_3ABC, 0, 20'h00000, 0, 32'h0000_3ABC, 0}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_acc(input logic rel, input logic [31:0] va, input int lat,
                         input logic [19:0] ppn, input int inv_at,
                         output int cyc, output logic [31:0] pa, output int nreq);
    int wt;
    wt = 0; cyc = 0; nreq = 0;
    acc_valid = 1'b1; reloc_en = rel; acc_vaddr = va;
    #1;
    while (!acc_done && cyc < 100) begin
      if (!acc_busy) bad_busy = 1;
      if (l2_req) begin
        if (l2_vpn != va[31:12]) bad_vpn = 1;
        if (ins_grant) bad_pri = 1;
        if (wt == lat) begin
          l2_resp_valid = 1'b1; l2_resp_ppn = ppn; nreq++; wt = 0;
        end else wt++;
      end else if (!ins_grant) bad_pri = 1;
      if (cyc == inv_at) inv_all = 1'b1;
      @(posedge clk); @(negedge clk);
      l2_resp_valid = 1'b0; inv_all = 1'b0; cyc++;
      #1;
    end
    pa = acc_paddr;
    if (acc_busy) bad_busy = 1;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic expect_acc(input logic [31:0] va, input int lat, input logic [19:0] ppn,
                            input int exp_cyc, input string req);
    int c, n;
    logic [31:0] p;
    run_acc(1'b1, va, lat, ppn, -1, c, p, n);
    chk(c == exp_cyc, req, c, exp_cyc);
  endtask

  task automatic pulse_inv();
    @(negedge clk); inv_all = 1'b1;
    @(negedge clk); inv_all = 1'b0;
  endtask

  initial begin
    int c, n;
    logic [31:0] p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!l2_req && !acc_busy, "R1 idle after reset", {l2_req, acc_busy}, 0);
    chk(ins_grant == 1'b1, "R10 grant when idle", ins_grant, 1);
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      run_acc(VEC[i].rel, VEC[i].va, VEC[i].lat, VEC[i].ppn, -1, c, p, n);
      chk(c == VEC[i].cyc, "R5/R3 table latency", c, VEC[i].cyc);
      chk(p == VEC[i].pa, "R3/R2 table paddr", p, VEC[i].pa);
      chk(n == VEC[i].nreq, "R4/R2 table requests", n, VEC[i].nreq);
    end

    pulse_inv();
    expect_acc(32'h0000_1000, 0, 20'hA0001, 3, "R9 miss after invalidate");

    pulse_inv();
    for (int i = 0; i < 8; i++)
      expect_acc({20'h00100 + 20'(i), 12'h000}, i % 3, 20'hC0000 + 20'(i), 3 + (i % 3),
                 "R7 fill slot");
    for (int i = 0; i < 3; i++)
      expect_acc(32'h0010_0000, 0, 20'h0, 0, "R8 hits keep order");
    expect_acc(32'h0010_8000, 0, 20'hC0008, 3, "R7 wrap install");
    run_acc(1'b1, 32'h0010_2444, 0, 20'h0, -1, c, p, n);
    chk(c == 0 && p == 32'hC000_2444, "R7 survivor hit", p, 32'hC000_2444);
    expect_acc(32'h0010_0000, 0, 20'hC0000, 3, "R7 oldest evicted");

    run_acc(1'b1, 32'h0020_0008, 0, 20'hD0200, 2, c, p, n);
    chk(c == 6, "R9 install dropped latency", c, 6);
    chk(n == 2, "R9 second request", n, 2);
    chk(p == 32'hD020_0008, "R9 final paddr", p, 32'hD020_0008);
    expect_acc(32'h0010_2000, 0, 20'hC0002, 3, "R9 prior entries cleared");

    chk(!bad_busy, "R6 busy while pending", bad_busy, 0);
    chk(!bad_vpn, "R4 request page number", bad_vpn, 0);
    chk(!bad_pri, "R10 data side priority", bad_pri, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule